// File: doc/BRIEF.md
# Burst and Page Address Sequencer

This block supplies the byte address used while a serial flash array is read or programmed. A command loads a start address while chip select is low, and each per-byte advance strobe moves the address on by one byte. Where the address goes after the last byte of a region depends on the kind of command. A plain read walks the whole 1 MB array and rolls over to zero. A burst-capable read can be confined to an aligned window of 8, 16, 32 or 64 bytes. A program operation stays inside its 256-byte page.

The window used by burst-capable reads comes from a 3-bit setting, written by a set-burst strobe. The setting stays in place across any number of later commands. Chip select going high ends the current command. After that, advance strobes have no effect until a new start address is loaded. The array itself, the serial data path and command decode are outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is active, and on the first cycle after it, `addr` is 000000h and the stored wrap setting is 3'b001, which means wrap disabled. A burst-capable read issued before any set-burst therefore steps linearly.
- R2: When `load` is high and `cs_n` is low, `addr` takes the value `start_addr` modulo 2^MEM_AW (default 1 MB) on the next cycle. `op_kind` is captured for the command at the same time. A `load` in the same cycle as `advance` takes priority over the advance.
- R3: For `op_kind` 2'b00 (plain read), each accepted advance adds one to `addr`, and 0FFFFFh is followed by 000000h.
- R4: A `set_burst` pulse stores `wrap_cfg`. Bit [0] is the disable flag: 0 turns wrapping on and 1 turns it off. Bits [2:1] select the window: 00 = 8 bytes, 01 = 16, 10 = 32, 11 = 64.
- R5: For `op_kind` 2'b01 (burst-capable read) with wrapping on, the address counts up from the loaded start. After the last byte of the aligned window that holds the start, it returns to the first byte of that window. The bits above the window never change.
- R6: For `op_kind` 2'b01 with the disable flag set, stepping is the same as in R3.
- R7: The stored setting applies to every later burst-capable read, across chip-select cycles. Only another `set_burst` replaces it.
- R8: For `op_kind` 2'b10 (page program), the address counts within its 256-byte page: xxxxFFh is followed by xxxx00h.
- R9: While `cs_n` is high, `addr` holds, and `advance` and `load` have no effect. After `cs_n` goes low, `advance` has no effect until a `load` starts a new command.
- R10: `op_kind` 2'b00 ignores the stored wrap setting. `op_kind` 2'b11 behaves as 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select; high ends the command |
| load | input | 1 | Load `start_addr` and `op_kind` for a new command |
| start_addr | input | 24 | Start byte address |
| op_kind | input | 2 | 00 plain read, 01 burst-capable read, 10 page program, 11 as 00 |
| advance | input | 1 | One pulse per byte transferred |
| set_burst | input | 1 | Store `wrap_cfg` as the wrap setting |
| wrap_cfg | input | 3 | [2:1] window size, [0] wrap disable |
| addr | output | 24 | Current byte address |

## Verification
The bench sends each window size a start offset in the middle of its window and advances past the end of the window. A design with a wrong mask width would either leave the window early or climb into the next window. It also crosses the top of the array and the end of a program page. A counter that carried into the upper bits would show up there as an address above 0FFFFFh or as a move to the next page. The bench then runs two burst-capable reads with no set-burst between them, and checks that a plain read ignores an enabled window. A design that dropped the setting at chip select, or applied it to every read, would miscompare. Finally, it drives advance while chip select is high or before any load, and drives load and advance in the same cycle. This exposes stray steps and the wrong priority.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  parameter int unsigned ADDR_W    = 24;
  parameter int unsigned WIN_SEL_W = 2;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    OP_LINEAR = 2'b00,
    OP_BURST  = 2'b01,
    OP_PROG   = 2'b10,
    OP_RSVD   = 2'b11
  } op_kind_e;

  // [WIN_SEL_W:1] window size select, [0] wrap disable flag
  typedef struct packed {
    logic [WIN_SEL_W-1:0] size_sel;
    logic                 wrap_off;
  } wrap_cfg_t;

  // Increment only the bits under mask, keep the rest
  function automatic addr_t masked_inc(addr_t cur, addr_t mask);
    addr_t bumped;
    bumped = cur + addr_t'(1);
    return (cur & ~mask) | (bumped & mask);
  endfunction

  // True when the masked field is at its last value
  function automatic logic at_field_end(addr_t cur, addr_t mask);
    return (cur & mask) == mask;
  endfunction
endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_addr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      set_burst,
  input  wrap_cfg_t cfg_in,
  output wrap_cfg_t cfg_q
);
  localparam wrap_cfg_t CFG_RESET = '{size_sel: '0, wrap_off: 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)         cfg_q <= CFG_RESET;
    else if (set_burst) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/burst_window_sel.sv
module burst_window_sel
  import burst_addr_pkg::*;
#(
  parameter int unsigned MEM_AW     = 20,
  parameter int unsigned PAGE_AW    = 8,
  parameter int unsigned MIN_WIN_AW = 3
) (
  input  op_kind_e  op,
  input  wrap_cfg_t cfg,
  output addr_t     step_mask,
  output logic      wrap_active
);
  localparam int unsigned N_WIN = 1 << WIN_SEL_W;
  localparam addr_t MEM_MASK  = {{(ADDR_W-MEM_AW){1'b0}},  {MEM_AW{1'b1}}};
  localparam addr_t PAGE_MASK = {{(ADDR_W-PAGE_AW){1'b0}}, {PAGE_AW{1'b1}}};

  addr_t win_masks [N_WIN];

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    localparam int unsigned W = MIN_WIN_AW + g;
    assign win_masks[g] = {{(ADDR_W-W){1'b0}}, {W{1'b1}}};
  end

  always_comb begin
    wrap_active = (op == OP_BURST) && !cfg.wrap_off;
    unique case (op)
      OP_PROG:  step_mask = PAGE_MASK;
      OP_BURST: step_mask = wrap_active ? win_masks[cfg.size_sel] : MEM_MASK;
      default:  step_mask = MEM_MASK;
    endcase
  end
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import burst_addr_pkg::*;
#(
  parameter int unsigned MEM_AW = 20
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_n,
  input  logic     load,
  input  addr_t    start_addr,
  input  op_kind_e op_in,
  input  logic     advance,
  input  addr_t    step_mask,
  output addr_t    addr_q,
  output op_kind_e op_q,
  output logic     step_en,
  output logic     window_wrap
);
  localparam addr_t MEM_MASK = {{(ADDR_W-MEM_AW){1'b0}}, {MEM_AW{1'b1}}};

  logic active_q;
  logic load_en;

  assign load_en     = load && !cs_n;
  assign step_en     = advance && active_q && !cs_n && !load;
  assign window_wrap = step_en && at_field_end(addr_q, step_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      op_q     <= OP_LINEAR;
      active_q <= 1'b0;
    end else if (cs_n) begin
      active_q <= 1'b0;
    end else if (load_en) begin
      addr_q   <= start_addr & MEM_MASK;
      op_q     <= op_in;
      active_q <= 1'b1;
    end else if (step_en) begin
      addr_q   <= masked_inc(addr_q, step_mask);
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int unsigned MEM_AW     = 20,
  parameter int unsigned PAGE_AW    = 8,
  parameter int unsigned MIN_WIN_AW = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        load,
  input  logic [23:0] start_addr,
  input  logic [1:0]  op_kind,
  input  logic        advance,
  input  logic        set_burst,
  input  logic [2:0]  wrap_cfg,
  output logic [23:0] addr
);
  wrap_cfg_t cfg_q;
  op_kind_e  op_q;
  addr_t     step_mask;
  addr_t     addr_q;
  logic      wrap_active;
  logic      step_en;
  logic      window_wrap;

  burst_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_burst (set_burst),
    .cfg_in    (wrap_cfg_t'(wrap_cfg)),
    .cfg_q     (cfg_q)
  );

  burst_window_sel #(
    .MEM_AW     (MEM_AW),
    .PAGE_AW    (PAGE_AW),
    .MIN_WIN_AW (MIN_WIN_AW)
  ) u_win (
    .op          (op_q),
    .cfg         (cfg_q),
    .step_mask   (step_mask),
    .wrap_active (wrap_active)
  );

  burst_addr_ctr #(
    .MEM_AW (MEM_AW)
  ) u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .load        (load),
    .start_addr  (start_addr),
    .op_in       (op_kind_e'(op_kind)),
    .advance     (advance),
    .step_mask   (step_mask),
    .addr_q      (addr_q),
    .op_q        (op_q),
    .step_en     (step_en),
    .window_wrap (window_wrap)
  );

  assign addr = addr_q;
endmodule

// File: rtl/burst_addr_chk.sv
module burst_addr_chk #(
  parameter int unsigned MEM_AW = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        load,
  input logic [23:0] start_addr,
  input logic        set_burst,
  input logic [2:0]  wrap_cfg,
  input logic [23:0] addr,
  input logic        step_en,
  input logic        window_wrap,
  input logic        wrap_active,
  input logic [23:0] step_mask,
  input logic [1:0]  op_q,
  input logic [2:0]  cfg_q
);
  localparam logic [23:0] MEM_MASK = {{(24-MEM_AW){1'b0}}, {MEM_AW{1'b1}}};

  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (addr == 24'h0 && cfg_q == 3'b001));

  a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !cs_n) |=> addr == ($past(start_addr) & MEM_MASK));

  a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !wrap_active && op_q != 2'b10)
      |=> addr == (($past(addr) + 24'd1) & MEM_MASK));

  a_r4_cfg_store: assert property (@(posedge clk) disable iff (!rst_n)
    set_burst |=> cfg_q == $past(wrap_cfg));

  a_r5_window_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && wrap_active)
      |=> (addr & ~$past(step_mask)) == ($past(addr) & ~$past(step_mask)));

  a_r5_window_return: assert property (@(posedge clk) disable iff (!rst_n)
    window_wrap |=> (addr & $past(step_mask)) == 24'h0);

  a_r8_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op_q == 2'b10) |=> addr[23:8] == $past(addr[23:8]));

  a_r9_hold_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(addr));
endmodule

bind burst_addr_gen burst_addr_chk #(.MEM_AW(MEM_AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .load        (load),
  .start_addr  (start_addr),
  .set_burst   (set_burst),
  .wrap_cfg    (wrap_cfg),
  .addr        (addr),
  .step_en     (step_en),
  .window_wrap (window_wrap),
  .wrap_active (wrap_active),
  .step_mask   (step_mask),
  .op_q        (op_q),
  .cfg_q       (cfg_q)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_SIZE   = 1 << 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n;
  logic        load;
  logic [23:0] start_addr;
  logic [1:0]  op_kind;
  logic        advance;
  logic        set_burst;
  logic [2:0]  wrap_cfg;
  logic [23:0] addr;

  int vectors = 0;
  int fails   = 0;

  // behavioural reference state
  int m_addr   = 0;
  int m_op     = 0;
  bit m_active = 0;
  bit m_off    = 1;
  int m_size   = 0;

  burst_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .load(load),
    .start_addr(start_addr), .op_kind(op_kind), .advance(advance),
    .set_burst(set_burst), .wrap_cfg(wrap_cfg), .addr(addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic compare(string tag);
    vectors++;
    if (addr !== 24'(m_addr)) begin
      fails++;
      $display("FAIL %s: addr=%06h expected %06h", tag, addr, 24'(m_addr));
    end
  endtask

  // Apply one cycle of inputs, advance the model, check at the next negedge
  task automatic cyc(string tag, bit cs, bit ld, int sa, int op, bit adv,
                     bit sb, int cfg);
    int region;
    cs_n = cs; load = ld; start_addr = 24'(sa); op_kind = 2'(op);
    advance = adv; set_burst = sb; wrap_cfg = 3'(cfg);
    @(posedge clk);
    if (cs) m_active = 0;
    else if (ld) begin
      m_active = 1;
      m_addr   = sa % MEM_SIZE;
      m_op     = (op == 3) ? 0 : op;
    end else if (adv && m_active) begin
      if (m_op == 2) region = 256;
      else if (m_op == 1 && !m_off) region = 8 << m_size;
      else region = MEM_SIZE;
      m_addr = (m_addr / region) * region + ((m_addr % region) + 1) % region;
    end
    if (sb) begin
      m_off  = cfg[0];
      m_size = cfg / 2;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic deselect(string tag);
    cyc(tag, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic start_cmd(string tag, int sa, int op);
    cyc(tag, 0, 1, sa, op, 0, 0, 0);
  endtask

  task automatic steps(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic set_wrap(string tag, int cfg);
    cyc(tag, 1, 0, 0, 0, 0, 1, cfg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; load = 1'b0; start_addr = '0; op_kind = '0;
    advance = 1'b0; set_burst = 1'b0; wrap_cfg = '0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    deselect("R1");
    // R1: wrap disabled after reset, burst read goes linear across 8-byte edge
    start_cmd("R1", 24'h000006, 1);
    steps("R1", 4);
    deselect("R1");

    // R2: start address is taken modulo the array size
    start_cmd("R2", 24'h123456, 0);
    // R2: load wins over a simultaneous advance
    cyc("R2", 0, 1, 24'h000ABC, 0, 1, 0, 0);
    deselect("R2");

    // R3: linear stepping and rollover at the top of the array
    start_cmd("R3", 24'h0FFFFD, 0);
    steps("R3", 5);
    deselect("R3");

    // R4 / R5: every window size with a start inside the window
    for (int s = 0; s < 4; s++) begin
      set_wrap("R4", s * 2);
      start_cmd("R5", 24'h0A0300 + (8 << s) * 3 + (8 << s) / 2 + 1, 1);
      steps("R5", (8 << s) + 3);
      deselect("R5");
    end

    // R6: window selected but disabled -> linear
    set_wrap("R6", 3'b011);
    start_cmd("R6", 24'h00003D, 1);
    steps("R6", 6);
    deselect("R6");

    // R7: setting survives across commands
    set_wrap("R7", 3'b010);
    start_cmd("R7", 24'h05001C, 1);
    steps("R7", 6);
    deselect("R7");
    deselect("R7");
    start_cmd("R7", 24'h07007B, 1);
    steps("R7", 8);
    deselect("R7");

    // R10: plain read and reserved op ignore the enabled window
    start_cmd("R10", 24'h00003E, 0);
    steps("R10", 4);
    deselect("R10");
    start_cmd("R10", 24'h00013C, 3);
    steps("R10", 6);
    deselect("R10");

    // R8: program wraps inside its page
    start_cmd("R8", 24'h0456FC, 2);
    steps("R8", 6);
    deselect("R8");

    // R9: deselected advance and load have no effect; advance needs a load
    start_cmd("R9", 24'h000200, 0);
    steps("R9", 2);
    cyc("R9", 1, 0, 0, 0, 1, 0, 0);
    cyc("R9", 1, 1, 24'h000777, 0, 1, 0, 0);
    cyc("R9", 0, 0, 0, 0, 1, 0, 0);
    cyc("R9", 0, 0, 0, 0, 1, 0, 0);
    start_cmd("R9", 24'h000300, 0);
    steps("R9", 1);
    deselect("R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule